// File: doc/BRIEF.md
# Bit-Reversed Memory-Mapped Port Decoder

This block sits between an 8-bit processor bus and a 256-byte on-chip RAM. It also serves a few special addresses. Two addresses are mapped to I/O. A write to either one loads a latched output port, and a read from either one returns the matching input port. Because the board wiring is reversed, every byte that passes through a port has its bit order flipped. Bit i on the bus side is bit 7-i on the pin side, in both directions.

A third address is the interrupt-acknowledge location. A read there returns the ordinary RAM byte. It also raises a one-cycle strobe that clears an external interrupt-request flip-flop. Every other address is plain RAM.

Reads have one cycle of latency. The RAM is synchronous, and port reads are registered so that they arrive in the same cycle as RAM reads. The read data then holds until the next read.

Top module: `bitrev_io_decoder`

## Requirements
- R1: A write with `addr` = 0xFB loads `out_port0`, and a write with `addr` = 0xFC loads `out_port1`. The new value is visible in the cycle after the write. Writes to these two addresses leave all RAM locations unchanged.
- R2: A read of 0xFB returns the bit-reversed `in_port0` value sampled at the request edge, and a read of 0xFC returns the bit-reversed `in_port1` value. Both appear on `rd_data` in the cycle after `rd_en`.
- R3: Port bit reversal maps bus bit i to port bit 7-i, for every i from 0 to 7, on both reads and writes.
- R4: A read of 0xFD returns the RAM byte stored at 0xFD. It also drives `irq_clr` high in the cycle after the request, and back-to-back reads give one high cycle each.
- R5: `irq_clr` is low in every cycle after reset that does not follow a read of 0xFD. Writes to 0xFD do not raise it.
- R6: Every address other than 0xFB and 0xFC is written to, and read from, a 256-byte RAM. The data is visible on `rd_data` one cycle after the read request.
- R7: While `rst` is high, `out_port0` and `out_port1` are 0x00, `rd_data` is 0x00, and `irq_clr` is held high so that any pending interrupt request is cleared.
- R8: A read and a write of the same RAM address in one cycle return the old byte. The new byte is returned by a later read.
- R9: `rd_data` keeps its value in cycles with `rd_en` low. An output port keeps its value in cycles without a write to its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Bus address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, one cycle after rd_en |
| out_port0 | output | 8 | Latched output port at 0xFB (bit-reversed) |
| out_port1 | output | 8 | Latched output port at 0xFC (bit-reversed) |
| in_port0 | input | 8 | Input port read at 0xFB |
| in_port1 | input | 8 | Input port read at 0xFC |
| irq_clr | output | 1 | Interrupt-request clear strobe |

## Verification
The inline properties check several rules on every cycle:
- each port write is reflected bit by bit, in reversed order, on the output port;
- a port read returns the reversed input sampled at the request edge;
- the clear strobe follows reads of 0xFD and nothing else;
- outputs hold while they are not addressed.

Only the bench scenarios can show the rest:
- that RAM contents survive port writes;
- that every RAM address stores and returns its own byte;
- the read-before-write result on a colliding access;
- the reset values of the output ports.

// File: rtl/bitrev_io_pkg.sv
package bitrev_io_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_ADDR_W = 8;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_RAM   = 2'd1,
    SRC_PORT0 = 2'd2,
    SRC_PORT1 = 2'd3
  } rd_src_e;
endpackage

// File: rtl/bitrev_swap.sv
module bitrev_swap #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/bitrev_io_addr_dec.sv
module bitrev_io_addr_dec
  import bitrev_io_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT0_ADDR = 'hFB,
  parameter logic [ADDR_W-1:0] PORT1_ADDR = 'hFC,
  parameter logic [ADDR_W-1:0] ACK_ADDR   = 'hFD
) (
  input  logic [ADDR_W-1:0] addr,
  output rd_src_e           region,
  output logic              hit_ack
);
  always_comb begin
    if (addr == PORT0_ADDR)      region = SRC_PORT0;
    else if (addr == PORT1_ADDR) region = SRC_PORT1;
    else                         region = SRC_RAM;
  end

  assign hit_ack = (addr == ACK_ADDR);
endmodule

// File: rtl/bitrev_io_ram.sv
module bitrev_io_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single port: the read register sees the pre-write contents.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/bitrev_io_ports.sv
module bitrev_io_ports
  import bitrev_io_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_src_e           region,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] in0,
  input  logic [DATA_W-1:0] in1,
  output logic [DATA_W-1:0] out0,
  output logic [DATA_W-1:0] out1,
  output logic [DATA_W-1:0] rd_port
);
  logic [DATA_W-1:0] wdata_rev, in0_rev, in1_rev;

  bitrev_swap #(.W(DATA_W)) u_sw_w  (.din(wdata), .dout(wdata_rev));
  bitrev_swap #(.W(DATA_W)) u_sw_i0 (.din(in0),   .dout(in0_rev));
  bitrev_swap #(.W(DATA_W)) u_sw_i1 (.din(in1),   .dout(in1_rev));

  always_ff @(posedge clk) begin
    if (rst) begin
      out0 <= '0;
      out1 <= '0;
    end else if (wr_en) begin
      if (region == SRC_PORT0) out0 <= wdata_rev;
      if (region == SRC_PORT1) out1 <= wdata_rev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_port <= '0;
    end else if (rd_en) begin
      if (region == SRC_PORT0)      rd_port <= in0_rev;
      else if (region == SRC_PORT1) rd_port <= in1_rev;
    end
  end

  AST_OUT0_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && region == SRC_PORT0) |=> $stable(out0)); // R9
  AST_OUT1_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && region == SRC_PORT1) |=> $stable(out1)); // R9
endmodule

// File: rtl/bitrev_io_decoder.sv
module bitrev_io_decoder
  import bitrev_io_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] PORT0_ADDR = 'hFB,
  parameter logic [ADDR_W-1:0] PORT1_ADDR = 'hFC,
  parameter logic [ADDR_W-1:0] ACK_ADDR   = 'hFD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] out_port0,
  output logic [DATA_W-1:0] out_port1,
  input  logic [DATA_W-1:0] in_port0,
  input  logic [DATA_W-1:0] in_port1,
  output logic              irq_clr
);
  rd_src_e           region;
  rd_src_e           src_q;
  logic              hit_ack;
  logic              ram_we, ram_re;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] port_rdata;

  bitrev_io_addr_dec #(
    .ADDR_W(ADDR_W), .PORT0_ADDR(PORT0_ADDR),
    .PORT1_ADDR(PORT1_ADDR), .ACK_ADDR(ACK_ADDR)
  ) u_dec (
    .addr(addr), .region(region), .hit_ack(hit_ack)
  );

  assign ram_we = wr_en && (region == SRC_RAM);
  assign ram_re = rd_en && (region == SRC_RAM);

  bitrev_io_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .addr(addr), .we(ram_we), .wdata(wdata),
    .re(ram_re), .rdata(ram_rdata)
  );

  bitrev_io_ports #(.DATA_W(DATA_W)) u_ports (
    .clk(clk), .rst(rst), .region(region), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .in0(in_port0), .in1(in_port1),
    .out0(out_port0), .out1(out_port1), .rd_port(port_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)        src_q <= SRC_NONE;
    else if (rd_en) src_q <= region;
  end

  // Held high through reset so the external request flip-flop starts clear.
  always_ff @(posedge clk) begin
    if (rst) irq_clr <= 1'b1;
    else     irq_clr <= rd_en && hit_ack;
  end

  always_comb begin
    unique case (src_q)
      SRC_RAM:   rd_data = ram_rdata;
      SRC_PORT0,
      SRC_PORT1: rd_data = port_rdata;
      default:   rd_data = '0;
    endcase
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ACK_ADDR) |=> irq_clr); // R4
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == ACK_ADDR) |=> !irq_clr); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R9

  for (genvar i = 0; i < DATA_W; i++) begin : g_chk
    AST_OUT0_REV: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == PORT0_ADDR) |=> out_port0[i] == $past(wdata[DATA_W-1-i])); // R3
    AST_OUT1_REV: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == PORT1_ADDR) |=> out_port1[i] == $past(wdata[DATA_W-1-i])); // R1
    AST_IN0_REV: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == PORT0_ADDR) |=> rd_data[i] == $past(in_port0[DATA_W-1-i])); // R2
  end
endmodule

// File: tb/bitrev_io_decoder_test.sv
module bitrev_io_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0, wdata = '0, in_port0 = '0, in_port1 = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data, out_port0, out_port1;
  logic       irq_clr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitrev_io_decoder uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .out_port0(out_port0),
    .out_port1(out_port1), .in_port0(in_port0), .in_port1(in_port1),
    .irq_clr(irq_clr)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v, output logic irq);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
    irq = irq_clr;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, exp;
    logic       irq;

    repeat (3) @(negedge clk);
    chk("R7 irq_clr in reset", {7'd0, irq_clr}, 8'h01);
    chk("R7 out_port0 reset", out_port0, 8'h00);
    chk("R7 out_port1 reset", out_port1, 8'h00);
    chk("R7 rd_data reset", rd_data, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 irq_clr idle after reset", {7'd0, irq_clr}, 8'h00);

    // R6/R1: fill every address, ports take their writes.
    for (int a = 0; a < 256; a++) do_write(8'(a), pat(a));
    chk("R1 out_port0 after sweep", out_port0, rev8(pat(8'hFB)));
    chk("R1 out_port1 after sweep", out_port1, rev8(pat(8'hFC)));
    chk("R5 no strobe on write to ack", {7'd0, irq_clr}, 8'h00);

    in_port0 = 8'h1E; in_port1 = 8'hC5;
    for (int a = 0; a < 256; a++) begin
      do_read(8'(a), v, irq);
      if (a == 8'hFB)      exp = rev8(8'h1E);
      else if (a == 8'hFC) exp = rev8(8'hC5);
      else                 exp = pat(a);
      chk((a == 8'hFB || a == 8'hFC) ? "R2 port read" : "R6 ram read", v, exp);
      if (a == 8'hFD) begin
        chk("R4 ack strobe", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R4 ack strobe one cycle", {7'd0, irq_clr}, 8'h00);
      end else begin
        chk("R5 no strobe", {7'd0, irq}, 8'h00);
      end
    end

    // R3: every input value through both ports.
    for (int x = 0; x < 256; x++) begin
      in_port0 = 8'(x); in_port1 = ~8'(x);
      do_read(8'hFB, v, irq);
      chk("R3 in0 reversal", v, rev8(8'(x)));
      do_read(8'hFC, v, irq);
      chk("R3 in1 reversal", v, rev8(~8'(x)));
    end

    // R3/R9: every output value through port 0, port 1 untouched.
    for (int x = 0; x < 256; x++) begin
      do_write(8'hFB, 8'(x));
      chk("R3 out0 reversal", out_port0, rev8(8'(x)));
      chk("R9 out1 holds", out_port1, rev8(pat(8'hFC)));
    end

    // R8: colliding read and write.
    @(negedge clk);
    addr = 8'h20; wdata = 8'hEE; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R8 collision returns old", rd_data, pat(8'h20));
    do_read(8'h20, v, irq);
    chk("R8 later read returns new", v, 8'hEE);

    // R9: read data holds while idle.
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      addr = 8'(k * 51);
      chk("R9 rd_data holds", rd_data, 8'hEE);
    end

    // R4: back-to-back acknowledge reads.
    @(negedge clk);
    addr = 8'hFD; rd_en = 1'b1;
    @(negedge clk);
    chk("R4 first pulse", {7'd0, irq_clr}, 8'h01);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R4 second pulse", {7'd0, irq_clr}, 8'h01);
    chk("R4 ack ram data", rd_data, pat(8'hFD));
    @(negedge clk);
    chk("R5 strobe drops", {7'd0, irq_clr}, 8'h00);

    // R7: reset again clears ports.
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 out_port0 re-reset", out_port0, 8'h00);
    chk("R7 out_port1 re-reset", out_port1, 8'h00);
    chk("R7 irq_clr re-reset", {7'd0, irq_clr}, 8'h01);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule